// File: doc/BRIEF.md
# SPI Byte Stream Idle/Escape Codec

This block sits between the byte shift register of an SPI slave and the packet layer of a bridge that turns SPI traffic into memory-mapped accesses. The SPI host clocks whenever it likes. So the slave must always have some byte to shift out, even when no response is ready. The codec fills such slots with a reserved idle byte. Because the idle value and the escape value are reserved, real data that equals either of them is sent as an escape pair.

On the receive side, each byte that the shift register delivers with a strobe is decoded. Unescaped idle bytes are dropped. An escape byte is consumed and arms a one-bit flag. The byte after an escape is flipped back with an XOR mask and forwarded, whatever its value. Every other byte is forwarded unchanged. On the transmit side, the shift register pulses a slot signal each time it loads a byte. In that slot the codec presents the idle byte, a plain data byte, the escape byte, or the second byte of a pending escape pair. It accepts upstream data through a valid/ready handshake that is qualified by the slot.

Top module: `spi_byte_codec`

## Requirements
- R1: While reset is asserted and right after it is released, `rx_data_vld` is low. An empty transmit slot presents 0x4A with `tx_data_rdy` high.
- R2: A strobed received byte other than 0x4A and 0x4D, with no escape pending, appears unchanged on `rx_data` with `rx_data_vld` high one clock after the strobe.
- R3: A strobed received 0x4A with no escape pending produces no output (`rx_data_vld` stays low).
- R4: A strobed received 0x4D with no escape pending produces no output. The next strobed byte is forwarded XORed with 0x20, even when it is 0x4A or 0x4D.
- R5: A pending receive escape is held across any number of clocks without a strobe.
- R6: In a transmit slot with `tx_data_vld` low and no escape pending, `tx_byte` is 0x4A and no data is accepted.
- R7: In a slot with no escape pending, a valid upstream byte other than 0x4A and 0x4D is presented as-is on `tx_byte`, and `tx_data_rdy` is high, so it is accepted.
- R8: An accepted upstream 0x4A is sent as 0x4D in its slot and 0x6A in the next slot.
- R9: An accepted upstream 0x4D is sent as 0x4D in its slot and 0x6D in the next slot.
- R10: `tx_data_rdy` is high only during a slot. It is low during the slot that carries the second byte of an escape pair.
- R11: The second byte of an escape pair is sent in the very next slot and is never replaced by 0x4A. This holds even when clocks without a slot intervene and the upstream byte changes.
- R12: Reset clears a pending escape in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_strobe | input | 1 | A received byte is present on `rx_byte` this cycle |
| rx_byte | input | 8 | Raw byte from the SPI shift register |
| rx_data_vld | output | 1 | Decoded byte valid (one cycle) |
| rx_data | output | 8 | Decoded data byte |
| tx_slot | input | 1 | Shift register loads `tx_byte` at this clock edge |
| tx_byte | output | 8 | Encoded byte for the shift register |
| tx_data_vld | input | 1 | Upstream byte offered |
| tx_data | input | 8 | Upstream data byte |
| tx_data_rdy | output | 1 | Upstream byte accepted when high together with valid |

## Verification
The assertions assume that `tx_slot` and `rx_strobe` are single-cycle qualifiers and that `tx_byte` is sampled only in the cycle of a slot. They also assume that `tx_data` stays stable while `tx_data_vld` is high, until ready is seen. The bench drives every input at the falling edge. It raises a slot or strobe for exactly one cycle and holds upstream data through the slot in which it is offered. It deliberately changes that data only after acceptance, to show that the pending escape partner comes from stored state.

// File: rtl/codec_pkg.sv
package codec_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  IDLE_BYTE = 8'h4A;
  localparam logic [7:0]  ESC_BYTE  = 8'h4D;
  localparam logic [7:0]  XOR_MASK  = 8'h20;
endpackage

// File: rtl/codec_rst_sync.sv
module codec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/codec_resv_det.sv
module codec_resv_det #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] IDLE = 8'h4A,
  parameter logic [W-1:0] ESC  = 8'h4D
) (
  input  logic [W-1:0] value,
  output logic         is_idle,
  output logic         is_esc
);
  assign is_idle = (value == IDLE);
  assign is_esc  = (value == ESC);
endmodule

// File: rtl/codec_rx.sv
module codec_rx #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] IDLE = 8'h4A,
  parameter logic [W-1:0] ESC  = 8'h4D,
  parameter logic [W-1:0] MASK = 8'h20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_byte,
  output logic         out_vld,
  output logic [W-1:0] out_byte
);
  logic         esc_q, esc_d;
  logic         ov_q, ov_d;
  logic [W-1:0] ob_q, ob_d;
  logic         ob_en;
  logic         hit_idle, hit_esc;

  codec_resv_det #(.W(W), .IDLE(IDLE), .ESC(ESC)) i_det (
    .value   (in_byte),
    .is_idle (hit_idle),
    .is_esc  (hit_esc)
  );

  always_comb begin
    esc_d = esc_q;
    ov_d  = 1'b0;
    ob_d  = ob_q;
    if (in_vld) begin
      if (esc_q) begin
        esc_d = 1'b0;
        ov_d  = 1'b1;
        ob_d  = in_byte ^ MASK;
      end else if (hit_esc) begin
        esc_d = 1'b1;
      end else if (!hit_idle) begin
        ov_d  = 1'b1;
        ob_d  = in_byte;
      end
    end
  end

  assign ob_en = ov_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      esc_q <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      esc_q <= esc_d;
      ov_q  <= ov_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ob_en) ob_q <= ob_d;
  end

  assign out_vld  = ov_q;
  assign out_byte = ob_q;

  // R3: a bare idle byte never yields output
  p_drop_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !esc_q && in_byte == IDLE) |=> !out_vld);

  // R4: an escape byte itself is silent and arms the flag
  p_esc_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !esc_q && in_byte == ESC) |=> (!out_vld && esc_q));

  // R4: byte after escape is forwarded flipped
  p_unescape_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && esc_q) |=> (out_vld && out_byte == ($past(in_byte) ^ MASK) && !esc_q));

  // R5: escape flag holds while no byte arrives
  p_esc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_q && !in_vld) |=> (esc_q && !out_vld));
endmodule

// File: rtl/codec_tx.sv
module codec_tx #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] IDLE = 8'h4A,
  parameter logic [W-1:0] ESC  = 8'h4D,
  parameter logic [W-1:0] MASK = 8'h20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         slot,
  input  logic         in_vld,
  input  logic [W-1:0] in_data,
  output logic         in_rdy,
  output logic [W-1:0] out_byte
);
  logic         pend_q, pend_d;
  logic [W-1:0] hold_q;
  logic         hold_en;
  logic         take;
  logic         hit_idle, hit_esc, reserved;

  codec_resv_det #(.W(W), .IDLE(IDLE), .ESC(ESC)) i_det (
    .value   (in_data),
    .is_idle (hit_idle),
    .is_esc  (hit_esc)
  );

  assign reserved = hit_idle | hit_esc;
  assign in_rdy   = slot & ~pend_q;
  assign take     = in_rdy & in_vld;
  assign hold_en  = take & reserved;

  always_comb begin
    if (pend_q)      out_byte = hold_q ^ MASK;
    else if (in_vld) out_byte = reserved ? ESC : in_data;
    else             out_byte = IDLE;
  end

  always_comb begin
    pend_d = pend_q;
    if (pend_q) begin
      if (slot) pend_d = 1'b0;
    end else if (hold_en) begin
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (hold_en) hold_q <= in_data;
  end

  // R10: ready only within a slot
  p_rdy_in_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy |-> slot);

  // R10: escape emitted in a slot is followed by a slot with ready low
  p_partner_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && in_vld && in_rdy && out_byte == ESC) |=> (!slot || !in_rdy));

  // R11: partner slot never carries the idle byte
  p_no_idle_in_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && slot) |-> (out_byte != IDLE));

  // R11: pending partner is held with its byte across slot-less cycles
  p_pend_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !slot) |=> (pend_q && $stable(out_byte)));
endmodule

// File: rtl/spi_byte_codec.sv
module spi_byte_codec
  import codec_pkg::*;
#(
  parameter int unsigned   W    = BYTE_W,
  parameter logic [W-1:0]  IDLE = IDLE_BYTE,
  parameter logic [W-1:0]  ESC  = ESC_BYTE,
  parameter logic [W-1:0]  MASK = XOR_MASK,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_strobe,
  input  logic [W-1:0] rx_byte,
  output logic         rx_data_vld,
  output logic [W-1:0] rx_data,
  input  logic         tx_slot,
  output logic [W-1:0] tx_byte,
  input  logic         tx_data_vld,
  input  logic [W-1:0] tx_data,
  output logic         tx_data_rdy
);
  logic rst_n_s;

  codec_rst_sync #(.STAGES(SYNC_STAGES)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  codec_rx #(.W(W), .IDLE(IDLE), .ESC(ESC), .MASK(MASK)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_vld   (rx_strobe),
    .in_byte  (rx_byte),
    .out_vld  (rx_data_vld),
    .out_byte (rx_data)
  );

  codec_tx #(.W(W), .IDLE(IDLE), .ESC(ESC), .MASK(MASK)) i_tx (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .slot     (tx_slot),
    .in_vld   (tx_data_vld),
    .in_data  (tx_data),
    .in_rdy   (tx_data_rdy),
    .out_byte (tx_byte)
  );
endmodule

// File: tb/test_spi_byte_codec.sv
module test_spi_byte_codec;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_strobe;
  logic [7:0] rx_byte;
  logic       rx_data_vld;
  logic [7:0] rx_data;
  logic       tx_slot;
  logic [7:0] tx_byte;
  logic       tx_data_vld;
  logic [7:0] tx_data;
  logic       tx_data_rdy;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  spi_byte_codec i_spi_byte_codec (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_strobe   (rx_strobe),
    .rx_byte     (rx_byte),
    .rx_data_vld (rx_data_vld),
    .rx_data     (rx_data),
    .tx_slot     (tx_slot),
    .tx_byte     (tx_byte),
    .tx_data_vld (tx_data_vld),
    .tx_data     (tx_data),
    .tx_data_rdy (tx_data_rdy)
  );

  // receive vectors: [16:9] byte in, [8] expect valid, [7:0] expected data
  localparam logic [16:0] RX_VEC [10] = '{
    {8'h41, 1'b1, 8'h41},  // R2
    {8'h4A, 1'b0, 8'h00},  // R3
    {8'h4D, 1'b0, 8'h00},  // R4
    {8'h4A, 1'b1, 8'h6A},  // R4
    {8'h4D, 1'b0, 8'h00},  // R4
    {8'h4D, 1'b1, 8'h6D},  // R4
    {8'h4D, 1'b0, 8'h00},  // R4
    {8'h41, 1'b1, 8'h61},  // R4
    {8'h00, 1'b1, 8'h00},  // R2
    {8'hFF, 1'b1, 8'hFF}   // R2
  };

  // transmit vectors: [17] valid, [16:9] data, [8:1] expected byte, [0] expected ready
  localparam logic [17:0] TX_VEC [9] = '{
    {1'b0, 8'h00, 8'h4A, 1'b1},  // R6
    {1'b1, 8'h41, 8'h41, 1'b1},  // R7
    {1'b1, 8'h4A, 8'h4D, 1'b1},  // R8
    {1'b1, 8'h4A, 8'h6A, 1'b0},  // R8 R10
    {1'b1, 8'h4D, 8'h4D, 1'b1},  // R9
    {1'b1, 8'h99, 8'h6D, 1'b0},  // R9 R10
    {1'b1, 8'h99, 8'h99, 1'b1},  // R7
    {1'b0, 8'h00, 8'h4A, 1'b1},  // R6
    {1'b1, 8'h7E, 8'h7E, 1'b1}   // R7
  };

  task automatic chk(input bit ok, input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_strobe = 1'b1;
    rx_byte   = b;
    @(negedge clk);
    rx_strobe = 1'b0;
  endtask

  task automatic tx_slot_check(input logic v, input logic [7:0] d, input logic [7:0] eb,
                               input logic er, input string req);
    @(negedge clk);
    tx_data_vld = v;
    tx_data     = d;
    tx_slot     = 1'b1;
    #1;
    chk(tx_byte == eb && tx_data_rdy == er, req, {tx_data_rdy, tx_byte}, {er, eb});
    @(negedge clk);
    tx_slot     = 1'b0;
    tx_data_vld = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(rx_data_vld == 1'b0, "R1 rx valid in reset", {8'h0, rx_data_vld}, 9'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_strobe = 1'b0; rx_byte = '0;
    tx_slot = 1'b0; tx_data_vld = 1'b0; tx_data = '0;
    do_reset();

    // R1: post-reset state
    chk(rx_data_vld == 1'b0, "R1 rx valid after reset", {8'h0, rx_data_vld}, 9'h0);
    tx_slot_check(1'b0, 8'h00, 8'h4A, 1'b1, "R1 idle slot after reset");

    // table walk: receive
    for (int i = 0; i < 10; i++) begin
      rx_send(RX_VEC[i][16:9]);
      if (RX_VEC[i][8])
        chk(rx_data_vld && rx_data == RX_VEC[i][7:0], "R2/R4 rx vector",
            {rx_data_vld, rx_data}, {1'b1, RX_VEC[i][7:0]});
      else
        chk(!rx_data_vld, "R3/R4 rx silent vector", {rx_data_vld, rx_data}, 9'h000);
    end

    // table walk: transmit
    for (int i = 0; i < 9; i++)
      tx_slot_check(TX_VEC[i][17], TX_VEC[i][16:9], TX_VEC[i][8:1], TX_VEC[i][0], "R6-R10 tx vector");

    // R5: escape survives idle clocks
    rx_send(8'h4D);
    repeat (4) @(negedge clk);
    chk(!rx_data_vld, "R5 no output while escape waits", {rx_data_vld, rx_data}, 9'h000);
    rx_send(8'h6A);
    chk(rx_data_vld && rx_data == 8'h4A, "R5 late partner unescaped", {rx_data_vld, rx_data}, 9'h14A);

    // R10: ready low outside a slot
    @(negedge clk);
    tx_data_vld = 1'b1; tx_data = 8'h41; tx_slot = 1'b0;
    #1;
    chk(!tx_data_rdy, "R10 ready outside slot", {tx_data_rdy, tx_byte}, {1'b0, tx_byte});
    tx_data_vld = 1'b0;

    // R11: partner follows across gaps and upstream changes
    tx_slot_check(1'b1, 8'h4A, 8'h4D, 1'b1, "R11 escape first byte");
    @(negedge clk);
    tx_data_vld = 1'b1; tx_data = 8'h41;
    repeat (3) @(negedge clk);
    tx_slot_check(1'b1, 8'h41, 8'h6A, 1'b0, "R11 partner after gap");
    tx_slot_check(1'b1, 8'h41, 8'h41, 1'b1, "R11 next data accepted");
    tx_slot_check(1'b0, 8'h00, 8'h4A, 1'b1, "R11 idle resumes");

    // R12: reset clears pending escapes both ways
    rx_send(8'h4D);
    tx_slot_check(1'b1, 8'h4D, 8'h4D, 1'b1, "R12 tx escape armed");
    do_reset();
    rx_send(8'h41);
    chk(rx_data_vld && rx_data == 8'h41, "R12 rx escape cleared", {rx_data_vld, rx_data}, 9'h141);
    tx_slot_check(1'b0, 8'h00, 8'h4A, 1'b1, "R12 tx escape cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule